// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 24-bit virtual address into a 32-bit physical address after a translation lookaside buffer miss. It reads descriptors from translation tables held in memory. The first-level table has sixteen word entries, and each entry covers one 1 MB region. An entry either maps its region directly as a section or points to a second-level table. That second-level table splits the region into 4 KB pages. The walk result is presented for one cycle so that the surrounding logic can write a TLB entry.

A walk starts in one of two ways. The first is a miss request on a valid/ready input. The second is a write to a prefetch tag register, which starts a walk before any miss has occurred. Walks happen only while the enable input is high. When the enable is low, the miss input is never accepted and prefetch writes are discarded.

While a walk is in progress, `miss_ready` stays low, so a waiting miss holds its request until the walker returns to idle. Descriptor reads use a request channel with valid/ready and a response channel with no back-pressure. At most one read is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: The first-level descriptor address is `{tbl_base_hi, tbl_base_lo}` plus four times virtual address bits [23:20].
- R2: A descriptor's type is held in its bits [1:0]. If a first-level descriptor has type 2'b10 (section), the walk needs exactly one read, and the result is descriptor bits [31:20] joined to virtual address bits [19:0], with `res_section` set to 1.
- R3: If a first-level descriptor has type 2'b01 (table pointer), a second read is issued at the descriptor with bits [1:0] cleared, plus four times virtual address bits [19:12]. If that second descriptor has type 2'b10, the result is its bits [31:12] joined to virtual address bits [11:0], with `res_section` set to 0.
- R4: A first-level type of 2'b00 or 2'b11, or a second-level type other than 2'b10, ends the walk with `res_fault` set to 1 and `res_pa` equal to zero.
- R5: `done` is high for exactly one cycle per walk. `busy` is high from the cycle after a walk is accepted up to and including the `done` cycle.
- R6: `miss_ready` is high only while the walker is idle and `cfg_en` is 1. A request is accepted on a cycle where both `miss_valid` and `miss_ready` are 1.
- R7: While `cfg_en` is 1, a `pf_wr` pulse stores `pf_va`, and that address is then walked. Its result has `res_prefetch` set to 1 and `res_va` equal to the written tag.
- R8: A `pf_wr` while `cfg_en` is 0 is discarded. No walk follows it, not even after the walker is enabled again.
- R9: A miss that arrives during a walk is held and is served after that walk. When the walker is idle, a valid miss goes ahead of a stored prefetch.
- R10: `rd_req_valid` and `rd_addr` stay stable until `rd_req_ready` is seen. No new request is issued while a read response is still pending.
- R11: During reset, `busy`, `done` and `rd_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Walker enable |
| tbl_base_hi | input | 16 | Upper half of first-level table base |
| tbl_base_lo | input | 16 | Lower half of first-level table base |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Miss request accepted when high with valid |
| miss_va | input | 24 | Virtual address of the miss |
| pf_wr | input | 1 | Prefetch tag register write strobe |
| pf_va | input | 24 | Prefetch virtual address tag |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_addr | output | 32 | Descriptor byte address |
| rd_rsp_valid | input | 1 | Read data valid (one cycle) |
| rd_rsp_data | input | 32 | Descriptor word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle walk completion pulse |
| res_va | output | 24 | Virtual address that was walked |
| res_pa | output | 32 | Translated physical address |
| res_fault | output | 1 | Walk ended on a fault descriptor |
| res_section | output | 1 | Result came from a section mapping |
| res_prefetch | output | 1 | Walk was started by a prefetch |

## Verification
The main function is exercised with ten virtual addresses, each aimed at a different kind of descriptor:
- section entries at the lowest and highest first-level index;
- page entries at the first and last second-level index of one table;
- a page in a second table;
- a fault at each level;
- a reserved first-level type;
- a prefetch.

Together these separate section joins from page joins, and show whether address bits are taken from the right fields at each level. Read latency and request stalls change from one vector to the next, which exposes any sampling of the response on the wrong cycle. Directed sequences then put a miss against a running prefetch, and a miss against a stored prefetch, to confirm the service order.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  localparam logic [1:0] DK_FAULT = 2'b00;
  localparam logic [1:0] DK_TABLE = 2'b01;
  localparam logic [1:0] DK_BLOCK = 2'b10;
endpackage

// File: rtl/xw_addr_calc.sv
module xw_addr_calc #(
  parameter int VA_W     = 24,
  parameter int PA_W     = 32,
  parameter int L1_IDX_W = 4,
  parameter int PG_OFF_W = 12
) (
  input  logic [PA_W-1:0] tbl_base,
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-3:0] desc_up,
  output logic [PA_W-1:0] l1_addr,
  output logic [PA_W-1:0] l2_addr,
  output logic [PA_W-1:0] sec_pa,
  output logic [PA_W-1:0] pg_pa
);
  localparam int SEC_OFF_W = VA_W - L1_IDX_W;
  localparam int L2_IDX_W  = SEC_OFF_W - PG_OFF_W;
  localparam int DU_W      = PA_W - 2;

  logic [L1_IDX_W-1:0] l1_idx;
  logic [L2_IDX_W-1:0] l2_idx;

  assign l1_idx  = va[VA_W-1 -: L1_IDX_W];
  assign l2_idx  = va[SEC_OFF_W-1:PG_OFF_W];

  // word-indexed table entries
  assign l1_addr = tbl_base + {{(PA_W-L1_IDX_W-2){1'b0}}, l1_idx, 2'b00};
  assign l2_addr = {desc_up, 2'b00} + {{(PA_W-L2_IDX_W-2){1'b0}}, l2_idx, 2'b00};

  // region base joined with region offset
  assign sec_pa  = {desc_up[DU_W-1 -: (PA_W-SEC_OFF_W)], va[SEC_OFF_W-1:0]};
  assign pg_pa   = {desc_up[DU_W-1 -: (PA_W-PG_OFF_W)], va[PG_OFF_W-1:0]};
endmodule

// File: rtl/xw_req_sel.sv
module xw_req_sel #(
  parameter int VA_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            idle,
  input  logic            miss_valid,
  input  logic [VA_W-1:0] miss_va,
  input  logic            pf_wr,
  input  logic [VA_W-1:0] pf_va,
  output logic            miss_ready,
  output logic            start,
  output logic [VA_W-1:0] start_va,
  output logic            start_pf
);
  logic            pf_pend;
  logic [VA_W-1:0] pf_tag;
  logic            miss_go;
  logic            pf_go;

  assign miss_ready = idle & cfg_en;
  assign miss_go    = miss_valid & miss_ready;
  // a waiting miss always goes ahead of a stored prefetch
  assign pf_go      = idle & cfg_en & pf_pend & ~miss_valid;
  assign start      = miss_go | pf_go;
  assign start_va   = miss_go ? miss_va : pf_tag;
  assign start_pf   = ~miss_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_pend <= 1'b0;
      pf_tag  <= '0;
    end else if (!cfg_en) begin
      pf_pend <= 1'b0;
    end else if (pf_wr) begin
      pf_pend <= 1'b1;
      pf_tag  <= pf_va;
    end else if (pf_go) begin
      pf_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int VA_W     = 24,
  parameter int PA_W     = 32,
  parameter int L1_IDX_W = 4,
  parameter int PG_OFF_W = 12,
  localparam int HALF_W  = PA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [HALF_W-1:0] tbl_base_hi,
  input  logic [HALF_W-1:0] tbl_base_lo,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VA_W-1:0]   miss_va,
  input  logic              pf_wr,
  input  logic [VA_W-1:0]   pf_va,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [PA_W-1:0]   rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [PA_W-1:0]   rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic [VA_W-1:0]   res_va,
  output logic [PA_W-1:0]   res_pa,
  output logic              res_fault,
  output logic              res_section,
  output logic              res_prefetch
);
  walk_st_e        st;
  logic [VA_W-1:0] cur_va;
  logic            cur_pf;
  logic [PA_W-1:0] req_addr;
  logic [PA_W-1:0] pa_q;
  logic            fault_q;
  logic            sec_q;

  logic            start;
  logic [VA_W-1:0] start_va;
  logic            start_pf;
  logic            idle;
  logic [VA_W-1:0] calc_va;
  logic [PA_W-1:0] l1_addr, l2_addr, sec_pa, pg_pa;
  logic [1:0]      dkind;

  assign idle    = (st == ST_IDLE);
  assign calc_va = idle ? start_va : cur_va;
  assign dkind   = rd_rsp_data[1:0];

  xw_req_sel #(.VA_W(VA_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .idle       (idle),
    .miss_valid (miss_valid),
    .miss_va    (miss_va),
    .pf_wr      (pf_wr),
    .pf_va      (pf_va),
    .miss_ready (miss_ready),
    .start      (start),
    .start_va   (start_va),
    .start_pf   (start_pf)
  );

  xw_addr_calc #(
    .VA_W(VA_W), .PA_W(PA_W), .L1_IDX_W(L1_IDX_W), .PG_OFF_W(PG_OFF_W)
  ) u_calc (
    .tbl_base (({tbl_base_hi, tbl_base_lo})),
    .va       (calc_va),
    .desc_up  (rd_rsp_data[PA_W-1:2]),
    .l1_addr  (l1_addr),
    .l2_addr  (l2_addr),
    .sec_pa   (sec_pa),
    .pg_pa    (pg_pa)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_va   <= '0;
      cur_pf   <= 1'b0;
      req_addr <= '0;
      pa_q     <= '0;
      fault_q  <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          cur_va   <= start_va;
          cur_pf   <= start_pf;
          req_addr <= l1_addr;
          sec_q    <= 1'b0;
          fault_q  <= 1'b0;
          st       <= ST_L1_REQ;
        end
        ST_L1_REQ: if (rd_req_ready) st <= ST_L1_WAIT;
        ST_L1_WAIT: if (rd_rsp_valid) begin
          if (dkind == DK_BLOCK) begin
            pa_q  <= sec_pa;
            sec_q <= 1'b1;
            st    <= ST_DONE;
          end else if (dkind == DK_TABLE) begin
            req_addr <= l2_addr;
            st       <= ST_L2_REQ;
          end else begin
            pa_q    <= '0;
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end
        end
        ST_L2_REQ: if (rd_req_ready) st <= ST_L2_WAIT;
        ST_L2_WAIT: if (rd_rsp_valid) begin
          if (dkind == DK_BLOCK) begin
            pa_q <= pg_pa;
          end else begin
            pa_q    <= '0;
            fault_q <= 1'b1;
          end
          st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign rd_addr      = req_addr;
  assign busy         = !idle;
  assign done         = (st == ST_DONE);
  assign res_va       = cur_va;
  assign res_pa       = pa_q;
  assign res_fault    = fault_q;
  assign res_section  = sec_q;
  assign res_prefetch = cur_pf;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic            miss_valid,
  input logic            miss_ready,
  input logic            busy,
  input logic            done,
  input logic            rd_req_valid,
  input logic            rd_req_ready,
  input logic [PA_W-1:0] rd_addr,
  input logic            rd_rsp_valid,
  input logic [PA_W-1:0] res_pa,
  input logic            res_fault
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            outstanding <= 1'b0;
    else if (rd_req_valid && rd_req_ready) outstanding <= 1'b1;
    else if (rd_rsp_valid)                 outstanding <= 1'b0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (miss_valid && miss_ready) |=> busy); // R6
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n) miss_ready |-> (cfg_en && !busy)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) outstanding |-> !rd_req_valid); // R10
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) (done && res_fault) |-> (res_pa == '0)); // R4
endmodule

bind xlat_walker xlat_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .busy         (busy),
  .done         (done),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_addr      (rd_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .res_pa       (res_pa),
  .res_fault    (res_fault)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [15:0] tbl_base_hi = 16'h0005;
  logic [15:0] tbl_base_lo = 16'h0100;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [23:0] miss_va = '0;
  logic        pf_wr = 1'b0;
  logic [23:0] pf_va = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        busy, done, res_fault, res_section, res_prefetch;
  logic [23:0] res_va;
  logic [31:0] res_pa;

  always #4 clk = ~clk;

  xlat_walker u_dut (.*);

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: 4 KB window indexed by address bits [11:2]
  logic [31:0] mem [0:1023];
  logic [31:0] addr_log [0:255];
  int          total_reads = 0;
  int          lat_cfg = 0;
  bit          stall_en = 0;
  bit          m_pend = 0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;
  int          cyc = 0;

  always @(negedge clk) begin
    cyc++;
    rd_req_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
    if (rd_rsp_valid) rd_rsp_valid = 1'b0;
    if (!rst_n) begin
      m_pend = 0;
    end else if (m_pend) begin
      if (m_cnt == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[m_addr[11:2]];
        m_pend       = 0;
      end else m_cnt--;
    end else if (rd_req_valid && rd_req_ready) begin
      m_pend = 1;
      m_addr = rd_addr;
      m_cnt  = lat_cfg;
      addr_log[total_reads[7:0]] = rd_addr;
      total_reads++;
    end
  end

  // captured result
  logic [31:0] c_pa;
  logic [23:0] c_va;
  logic        c_flt, c_sec, c_pf;

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1; c_pa = res_pa; c_va = res_va;
        c_flt = res_fault; c_sec = res_section; c_pf = res_prefetch;
        break;
      end
    end
  endtask

  task automatic issue_miss(input logic [23:0] va);
    @(negedge clk);
    miss_valid = 1'b1; miss_va = va;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic issue_pf(input logic [23:0] va);
    @(negedge clk);
    pf_wr = 1'b1; pf_va = va;
    @(negedge clk);
    pf_wr = 1'b0;
  endtask

  typedef struct packed {
    logic [23:0] va;
    logic        pf;
    logic [31:0] pa;
    logic        flt;
    logic        sec;
    logic [31:0] l1a;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{24'h012345, 1'b0, 32'h12312345, 1'b0, 1'b1, 32'h00050100},
    '{24'hFABCDE, 1'b0, 32'hFFFABCDE, 1'b0, 1'b1, 32'h0005013C},
    '{24'h100123, 1'b0, 32'hABCDE123, 1'b0, 1'b0, 32'h00050104},
    '{24'h1FFFFF, 1'b0, 32'h55555FFF, 1'b0, 1'b0, 32'h00050104},
    '{24'h105000, 1'b0, 32'h00000000, 1'b1, 1'b0, 32'h00050104},
    '{24'h200000, 1'b0, 32'h00000000, 1'b1, 1'b0, 32'h00050108},
    '{24'h301ABC, 1'b0, 32'h00042ABC, 1'b0, 1'b0, 32'h0005010C},
    '{24'h303000, 1'b0, 32'h00000000, 1'b1, 1'b0, 32'h0005010C},
    '{24'h400000, 1'b0, 32'h00000000, 1'b1, 1'b0, 32'h00050110},
    '{24'h100ABC, 1'b1, 32'hABCDEABC, 1'b0, 1'b0, 32'h00050104}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    bit seen;
    bit any;
    int snap;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[10'h040] = 32'h12300002;  // L1[0] section
    mem[10'h041] = 32'h00000401;  // L1[1] -> table at 0x400
    mem[10'h042] = 32'h00000000;  // L1[2] fault
    mem[10'h043] = 32'h00000801;  // L1[3] -> table at 0x800
    mem[10'h044] = 32'h00000003;  // L1[4] reserved
    mem[10'h04F] = 32'hFFF00002;  // L1[15] section
    mem[10'h100] = 32'hABCDE002;
    mem[10'h1FF] = 32'h55555002;
    mem[10'h105] = 32'h00000000;
    mem[10'h201] = 32'h00042002;
    mem[10'h203] = 32'h00777001;  // wrong type at second level

    repeat (3) @(negedge clk);
    chk(busy == 0, "R11 busy in reset", 32'(busy), 0);
    chk(done == 0, "R11 done in reset", 32'(done), 0);
    chk(rd_req_valid == 0, "R11 rd_req_valid in reset", 32'(rd_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready == 0, "R6 ready while disabled", 32'(miss_ready), 0);

    // R8: prefetch while disabled is discarded
    snap = total_reads;
    issue_pf(24'h012345);
    any = 0;
    repeat (10) begin @(negedge clk); any |= busy; end
    cfg_en = 1'b1;
    repeat (10) begin @(negedge clk); any |= busy | done; end
    chk(any == 0, "R8 no walk after disabled prefetch", 32'(any), 0);
    chk(total_reads == snap, "R8 no reads", 32'(total_reads - snap), 0);

    // R6: miss not accepted while disabled
    cfg_en = 1'b0;
    miss_valid = 1'b1; miss_va = 24'h012345;
    any = 0;
    repeat (6) begin @(negedge clk); any |= miss_ready | busy; end
    chk(any == 0, "R6 miss held off while disabled", 32'(any), 0);
    miss_valid = 1'b0;
    cfg_en = 1'b1;
    @(negedge clk);
    chk(miss_ready == 1, "R6 ready when idle and enabled", 32'(miss_ready), 1);

    // vector table
    for (int v = 0; v < 10; v++) begin
      logic [31:0] exp_l2;
      int exp_n;
      lat_cfg  = v % 3;
      stall_en = (v % 2) == 1;
      snap = total_reads;
      if (VECS[v].pf) issue_pf(VECS[v].va);
      else begin
        issue_miss(VECS[v].va);
        chk(busy == 1, "R5 busy after accept", 32'(busy), 1);
      end
      wait_done(seen);
      chk(seen, "R5 done seen", 32'(seen), 1);
      chk(c_flt == VECS[v].flt, "R4 fault flag", 32'(c_flt), 32'(VECS[v].flt));
      chk(c_pa == VECS[v].pa, VECS[v].sec ? "R2 section pa" : "R3 page pa", c_pa, VECS[v].pa);
      chk(c_sec == VECS[v].sec, "R2 section flag", 32'(c_sec), 32'(VECS[v].sec));
      chk(c_pf == VECS[v].pf, "R7 prefetch flag", 32'(c_pf), 32'(VECS[v].pf));
      chk(c_va == VECS[v].va, "R7 result va", 32'(c_va), 32'(VECS[v].va));
      chk(addr_log[snap[7:0]] == VECS[v].l1a, "R1 first-level address", addr_log[snap[7:0]], VECS[v].l1a);
      exp_n = (VECS[v].sec || VECS[v].l1a[3:0] == 4'h8 || VECS[v].l1a[3:0] == 4'h0 && !VECS[v].sec) ? 1 : 2;
      if (VECS[v].l1a == 32'h00050110) exp_n = 1;
      chk(total_reads - snap == exp_n, "R10 read count", 32'(total_reads - snap), 32'(exp_n));
      if (exp_n == 2) begin
        exp_l2 = ((VECS[v].va[23:20] == 4'h1) ? 32'h400 : 32'h800) + {22'd0, VECS[v].va[19:12], 2'b00};
        chk(addr_log[snap[7:0] + 8'd1] == exp_l2, "R3 second-level address", addr_log[snap[7:0] + 8'd1], exp_l2);
      end
      @(negedge clk);
      chk(done == 0 && busy == 0, "R5 done one cycle", {30'd0, done, busy}, 0);
    end
    stall_en = 0; lat_cfg = 1;

    // R9: miss arriving during a prefetch walk is held
    issue_pf(24'h100123);
    @(negedge clk);
    miss_valid = 1'b1; miss_va = 24'h012345;
    chk(miss_ready == 0 && busy == 1, "R9 miss held during walk", {30'd0, miss_ready, busy}, 1);
    wait_done(seen);
    chk(seen && c_pf == 1 && c_va == 24'h100123, "R9 prefetch served first", {7'd0, c_pf, c_va}, {8'd1, 24'h100123});
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    wait_done(seen);
    chk(seen && c_pf == 0 && c_pa == 32'h12312345, "R9 held miss served after", c_pa, 32'h12312345);

    // R9: miss goes ahead of a stored prefetch
    issue_miss(24'h100123);
    @(negedge clk);
    pf_wr = 1'b1; pf_va = 24'h012345;
    @(negedge clk);
    pf_wr = 1'b0;
    miss_valid = 1'b1; miss_va = 24'hFABCDE;
    wait_done(seen);
    chk(seen && c_va == 24'h100123, "R9 first walk", 32'(c_va), 32'h100123);
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    wait_done(seen);
    chk(seen && c_pf == 0 && c_va == 24'hFABCDE, "R9 miss before prefetch", {7'd0, c_pf, c_va}, {8'd0, 24'hFABCDE});
    wait_done(seen);
    chk(seen && c_pf == 1 && c_pa == 32'h12312345, "R7 stored prefetch walked", c_pa, 32'h12312345);

    summary();
  end
endmodule